// File: doc/BRIEF.md
# SSI Encoder-Side Slave Transmitter

This block is the sensor end of a synchronous serial interface link. A position word arrives in parallel and may change on any cycle. A master clock arrives on `sclk_i`, which has already been converted from its differential form and idles high. The block returns the position serially on `sdo_o`. While the link is quiet, the output rests high and the internal word tracks the live position.

The master begins a burst by pulling the clock low. That first falling edge freezes the position. Each rising edge then presents one bit, most significant first. One rising edge after the last bit, the line is driven low.

A retriggerable timeout frames every transfer, and any clock edge restarts it. If the master keeps clocking before the timeout ends, the same frozen word is sent again from its top bit. If the clock stays quiet until the timeout ends, the block returns to idle, whether the word was finished or cut short. The next burst then takes a fresh sample.

The clock input is brought into the system domain through a synchroniser, and its edges are detected there. The system clock must therefore run at least eight times faster than the serial clock.

Top module: `ssi_slave_tx`

## Requirements
- R1: After reset, and at any time while no transfer is active, `sdo_o` is 1, whatever values `pos_i` takes.
- R2: The falling edge of `sclk_i` that starts a burst captures `pos_i`. Changes on `pos_i` after that point do not alter the bits sent in the transfer.
- R3: Rising edges 1 to WORD_W of a burst present the captured word on `sdo_o`, bit WORD_W-1 on the first rising edge and bit 0 on rising edge WORD_W.
- R4: Rising edge WORD_W+1 drives `sdo_o` to 0. It stays 0 while clock edges keep arriving less than TIMEOUT_CYC system cycles apart, until the next rising edge.
- R5: A rising edge that arrives during the trailing low, before the timeout ends, restarts the same captured word at bit WORD_W-1. `pos_i` is not sampled again.
- R6: When TIMEOUT_CYC system cycles pass with no edge on `sclk_i`, `sdo_o` returns to 1 and the block goes idle. The next burst captures the current `pos_i`.
- R7: A burst stopped part way through a word ends the same way as in R6. The following burst starts again at bit WORD_W-1 of a freshly captured word.
- R8: `sdo_o` changes on the third system clock edge after a change on `sclk_i` (two synchroniser stages plus the output register). It returns to 1 exactly TIMEOUT_CYC system cycles after the output update caused by the last clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pos_i | input | WORD_W | Live position word |
| sclk_i | input | 1 | Serial clock from the master; idles high |
| sdo_o | output | 1 | Serial data to the master |

## Verification
The hardest case to reach is retransmission. The master must send the extra rising edge for the trailing low and then pause for most of the timeout, but not all of it. Only then can it resume clocking.

The stimulus changes `pos_i` during that pause and then reads the line again. The word that comes back must be the old one. A second run lets the pause run past the timeout, and a third stops in the middle of a word, to show that a fresh value is picked up.

A behavioural model in the bench tracks the exact cycle of every output change, so latency and timeout length are checked cycle for cycle.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } ssi_st_e;
endpackage

// File: rtl/ssi_clk_sync.sv
module ssi_clk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // reset to the line's idle level so no edge is seen at release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sclk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ssi_timeout.sv
module ssi_timeout #(
  parameter int unsigned TIMEOUT_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  // any edge reloads: retriggerable window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (kick_i) begin
      cnt_q <= CNT_W'(TIMEOUT_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire_o = (cnt_q == CNT_W'(1)) && !kick_i;
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter
  import ssi_pkg::*;
#(
  parameter int unsigned WORD_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] pos_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              expire_i,
  output logic              sdo_o,
  output ssi_st_e           state_o,
  output logic [WORD_W-1:0] word_o,
  output logic [$clog2(WORD_W+1)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W + 1);

  ssi_st_e           state_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      sdo_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // track live value until a burst begins
          word_q <= pos_i;
          sh_q   <= pos_i;
          sdo_q  <= 1'b1;
          idx_q  <= '0;
          if (fall_i) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (expire_i) begin
            state_q <= ST_IDLE;
            sdo_q   <= 1'b1;
          end else if (rise_i) begin
            if (idx_q == IDX_W'(WORD_W)) begin
              sdo_q   <= 1'b0;
              idx_q   <= '0;
              state_q <= ST_TRAIL;
            end else begin
              sdo_q <= sh_q[WORD_W-1];
              sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (expire_i) begin
            state_q <= ST_IDLE;
            sdo_q   <= 1'b1;
          end else if (rise_i) begin
            // retransmit frozen word, MSB now
            sdo_q   <= word_q[WORD_W-1];
            sh_q    <= {word_q[WORD_W-2:0], 1'b0};
            idx_q   <= IDX_W'(1);
            state_q <= ST_SHIFT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sdo_o   = sdo_q;
  assign state_o = state_q;
  assign word_o  = word_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/ssi_slave_tx.sv
module ssi_slave_tx
  import ssi_pkg::*;
#(
  parameter int unsigned WORD_W      = 25,
  parameter int unsigned TIMEOUT_CYC = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] pos_i,
  input  logic              sclk_i,
  output logic              sdo_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W + 1);

  logic              rise;
  logic              fall;
  logic              expire;
  ssi_st_e           state;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  idx;

  ssi_clk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  ssi_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (rise | fall),
    .expire_o (expire)
  );

  ssi_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .expire_i (expire),
    .sdo_o    (sdo_o),
    .state_o  (state),
    .word_o   (word),
    .idx_o    (idx)
  );
endmodule

// File: rtl/ssi_slave_tx_chk.sv
module ssi_slave_tx_chk
  import ssi_pkg::*;
#(
  parameter int unsigned WORD_W = 25
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        sdo_o,
  input logic                        rise,
  input logic                        expire,
  input ssi_st_e                     state,
  input logic [WORD_W-1:0]           word,
  input logic [$clog2(WORD_W+1)-1:0] idx
);
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> sdo_o);

  // R2
  frozen_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |=> $stable(word));

  // R3
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx <= ($clog2(WORD_W+1))'(WORD_W));

  // R4
  trail_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TRAIL) |-> !sdo_o);

  // R5
  retx_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TRAIL && rise) |=> (sdo_o == $past(word[WORD_W-1])) && state == ST_SHIFT);

  // R6
  expire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (state == ST_IDLE) && sdo_o);
endmodule

bind ssi_slave_tx ssi_slave_tx_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sdo_o  (sdo_o),
  .rise   (rise),
  .expire (expire),
  .state  (state),
  .word   (word),
  .idx    (idx)
);

// File: tb/test_ssi_slave_tx.sv
module test_ssi_slave_tx;
  localparam int W   = 25;
  localparam int TMO = 100;
  localparam int H   = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] pos_i = '0;
  logic         sclk_i = 1'b1;
  logic         sdo_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  ssi_slave_tx #(.WORD_W(W), .TIMEOUT_CYC(TMO)) i_ssi_slave_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_i), .sclk_i(sclk_i), .sdo_o(sdo_o)
  );

  // behavioural reference, cycle accurate
  logic         ma, mb, mc;
  int           m_cnt, m_st, m_idx;
  logic [W-1:0] m_word;
  logic         m_sdo = 1'b1;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ma = 1; mb = 1; mc = 1; m_cnt = 0; m_st = 0; m_idx = 0; m_word = '0; m_sdo = 1;
    end else begin
      automatic bit r  = mb && !mc;
      automatic bit f  = !mb && mc;
      automatic bit ex = (m_cnt == 1) && !(r || f);
      if (r || f) m_cnt = TMO; else if (m_cnt > 0) m_cnt--;
      if (m_st == 0) begin
        m_word = pos_i; m_sdo = 1; m_idx = 0;
        if (f) m_st = 1;
      end else if (ex) begin
        m_st = 0; m_sdo = 1;
      end else if (r) begin
        if (m_st == 2) begin
          m_sdo = m_word[W-1]; m_idx = 1; m_st = 1;
        end else if (m_idx == W) begin
          m_sdo = 0; m_st = 2; m_idx = 0;
        end else begin
          m_sdo = m_word[W-1-m_idx]; m_idx++;
        end
      end
      mc = mb; mb = ma; ma = sclk_i;
    end
  end

  // R8: per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      total++;
      if (sdo_o !== m_sdo) begin
        bad++;
        $display("FAIL R8 t=%0t sdo_o act=%b exp=%b", $time, sdo_o, m_sdo);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(output logic b);
    @(negedge clk_i); sclk_i = 1'b0;
    idle(H);
    sclk_i = 1'b1;
    idle(H);
    b = sdo_o;
  endtask

  // reads nb bits; after the first bit pos_i is set to nxt
  task automatic read_bits(input int nb, input logic [W-1:0] nxt, output logic [W-1:0] w);
    logic b;
    w = '0;
    for (int i = 0; i < nb; i++) begin
      pulse(b);
      if (i == 0) pos_i = nxt;
      w = {w[W-2:0], b};
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] w;
    logic         b;
    logic [W-1:0] pats [5];
    pats[0] = 25'h1555555; pats[1] = 25'h0AAAAAA; pats[2] = 25'h1000001;
    pats[3] = '1;          pats[4] = '0;
    pos_i = 25'h0123456;
    idle(5);
    rst_ni = 1'b1;
    idle(3);
    chk(sdo_o === 1'b1, "R1 reset idle", {24'b0, sdo_o}, 1);
    pos_i = 25'h1F0F0F0; idle(10);
    chk(sdo_o === 1'b1, "R1 idle with changing pos", {24'b0, sdo_o}, 1);

    // R2 R3: capture at first fall, MSB first, pos changed mid-burst
    pos_i = 25'h1234567;
    read_bits(W, 25'h0ABCDEF, w);
    chk(w === 25'h1234567, "R2 R3 frozen word", w, 25'h1234567);
    // R4: trailing low
    pulse(b);
    chk(b === 1'b0, "R4 trailing low", {24'b0, b}, 0);
    idle(TMO - 30);
    chk(sdo_o === 1'b0, "R4 low held inside window", {24'b0, sdo_o}, 0);
    // R5: resume before timeout -> same word
    read_bits(W, 25'h0111111, w);
    chk(w === 25'h1234567, "R5 retransmit same word", w, 25'h1234567);
    pulse(b);
    chk(b === 1'b0, "R4 second trailing low", {24'b0, b}, 0);
    // R6: timeout -> idle, fresh sample
    idle(TMO + 10);
    chk(sdo_o === 1'b1, "R6 high after timeout", {24'b0, sdo_o}, 1);
    read_bits(W, 25'h0222222, w);
    chk(w === 25'h0111111, "R6 fresh capture", w, 25'h0111111);
    pulse(b);
    idle(TMO + 10);

    // R7: abort mid-word
    pos_i = 25'h13C3C3C;
    read_bits(7, 25'h0765432, w);
    chk(w[6:0] === 7'b1001111, "R3 partial MSB bits", {18'b0, w[6:0]}, 25'h4F);
    idle(TMO + 10);
    chk(sdo_o === 1'b1, "R7 idle after abort", {24'b0, sdo_o}, 1);
    read_bits(W, 25'h0, w);
    chk(w === 25'h0765432, "R7 restart fresh from MSB", w, 25'h0765432);
    pulse(b);
    idle(TMO + 10);

    // R3: pattern sweep
    for (int k = 0; k < 5; k++) begin
      pos_i = pats[k];
      idle(4);
      read_bits(W, ~pats[k], w);
      chk(w === pats[k], "R3 pattern", w, pats[k]);
      pulse(b);
      chk(b === 1'b0, "R4 pattern trailing", {24'b0, b}, 0);
      idle(TMO + 10);
      chk(sdo_o === 1'b1, "R6 pattern timeout", {24'b0, sdo_o}, 1);
    end
    finish_run();
  end
endmodule